// File: doc/BRIEF.md
# Queued Asynchronous Serial Transmitter

This block is the transmit half of an asynchronous serial port. Bytes written by the host go into a small transmit queue. A framing engine takes them out one at a time and sends each one as a character on a single line. A character is a low start bit, then 7 or 8 data bits with the least significant bit first, then an optional even or odd parity bit, then one or two high stop bits. Bit timing comes from an external one-cycle baud tick, with one tick per bit period. Between characters the line rests high.

The queue is examined while the last stop bit is being sent. If a byte is waiting, the next start bit follows that stop bit with no idle time, so a full queue drains as one continuous burst. Three sticky flags serve the host:
- a queue-low flag, set while the fill level is at or below a selectable trigger and gated onto an interrupt request by an enable bit;
- a line-idle flag, set when a character ends with nothing left to send;
- an overflow flag, set when a write is lost because the queue is full.

Top module: `serial_tx_queue`

## Requirements
- R1: After reset `txd` is 1, `low_flag` is 1, `done_flag` is 1 and `ovf_flag` is 0. While no character is in progress, `txd` holds 1.
- R2: Each character starts with exactly one start bit at 0. The data bits follow, least significant bit first. With `cfg_len8`=1 all 8 bits of the byte are sent. With `cfg_len8`=0 bits 6..0 are sent and bit 7 is ignored.
- R3: When `cfg_par_en`=1, one parity bit follows the data bits. It equals the XOR of the data bits that were sent when `cfg_par_odd`=0, and the inverse of that XOR when `cfg_par_odd`=1. When `cfg_par_en`=0, no parity bit is sent.
- R4: The character ends with stop bits at 1: one stop bit when `cfg_stop2`=0, two when `cfg_stop2`=1.
- R5: Every bit lasts exactly one baud-tick interval. The first tick after a byte arrives in an idle transmitter begins its start bit, so `txd` falls within one tick interval plus one cycle of the write.
- R6: If the queue holds a byte when the last stop bit ends, that byte's start bit begins immediately. Consecutive start bits are then exactly one character length in tick intervals apart.
- R7: `low_flag` becomes 1 whenever the fill level is at or below the trigger level. `cfg_trig` selects the trigger: 0 selects level 0, 1 selects 2, 2 selects 4 and 3 selects 8. A pulse on `clr_low` clears the flag, but only if the fill level is above the trigger in that cycle.
- R8: `irq` is 1 exactly when `low_flag` is 1 and `irq_en` is 1.
- R9: `done_flag` is set when the last stop bit of a character ends and the queue is empty. It is cleared by a pulse on `clr_done` or by any accepted write.
- R10: The queue holds 16 bytes. A write while it is full is dropped and sets `ovf_flag`. `ovf_flag` stays set until a pulse on `clr_ovf`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| wr_en | input | 1 | Write strobe for the queue |
| wr_data | input | 8 | Byte to queue |
| cfg_len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_par_en | input | 1 | 1: parity bit sent |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_stop2 | input | 1 | 1: two stop bits, 0: one stop bit |
| cfg_trig | input | 2 | Queue-low trigger select (0, 2, 4, 8) |
| irq_en | input | 1 | Interrupt enable for the queue-low flag |
| clr_low | input | 1 | Write-one-to-clear pulse for `low_flag` |
| clr_done | input | 1 | Write-one-to-clear pulse for `done_flag` |
| clr_ovf | input | 1 | Write-one-to-clear pulse for `ovf_flag` |
| txd | output | 1 | Serial output line |
| low_flag | output | 1 | Fill level at or below trigger (sticky) |
| done_flag | output | 1 | Line went idle with the queue empty |
| ovf_flag | output | 1 | Write lost to a full queue |
| irq | output | 1 | Interrupt request |

## Verification
A write, a clear pulse or an overflow moves its flag at the next clock edge. `low_flag` follows a fill-level change one edge later. `txd` changes on the edge that samples a baud tick. The bench drives inputs on falling edges and reads flags at least one full cycle after the edge that must move them. The monitor finds each start bit on the first falling edge after `txd` drops. It then reads every bit at the centre of its 8-cycle period, so a one-cycle shift in any boundary cannot alter a sample. The same falling-edge timestamps let it compare the spacing of start bits against the character length for back-to-back traffic.

// File: rtl/stq_pkg.sv
package stq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP
   } tx_state_t;

   typedef struct packed {
      logic len8;
      logic par_en;
      logic par_odd;
      logic stop2;
   } frame_cfg_t;

endpackage

// File: rtl/stq_fifo.sv
module stq_fifo #(
   parameter int DW    = 8,
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [DW-1:0] wdata,
   input  logic          rd,
   output logic [DW-1:0] rdata,
   output logic [CW-1:0] count,
   output logic          empty,
   output logic          full,
   output logic          wr_ok,
   output logic          wr_lost
);

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wptr, rptr, wptr_nx, rptr_nx;
   logic          rd_ok;

   initial begin
      assert (DEPTH >= 2) else $fatal(1, "stq_fifo: DEPTH too small");
   end

   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   assign wr_ok   = wr && !full;
   assign wr_lost = wr && full;
   assign rd_ok   = rd && !empty;
   assign rdata   = mem[rptr];

   generate
      if ((1 << AW) == DEPTH) begin : g_pow2
         assign wptr_nx = wptr + 1'b1;
         assign rptr_nx = rptr + 1'b1;
      end else begin : g_wrap
         assign wptr_nx = (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
         assign rptr_nx = (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wptr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (wr_ok) wptr <= wptr_nx;
         if (rd_ok) rptr <= rptr_nx;
         case ({wr_ok, rd_ok})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   // R10: fill level never exceeds the depth
   a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));

   // R10: a write into a full queue with no read leaves the level alone
   a_r10_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (full && wr && !rd) |=> (count == $past(count)));

endmodule

// File: rtl/stq_framer.sv
module stq_framer
   import stq_pkg::*;
#(
   parameter int DW = 8,
   localparam int BW = $clog2(DW)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  frame_cfg_t    cfg,
   input  logic          q_empty,
   input  logic [DW-1:0] q_data,
   output logic          pop,
   output logic          idle_done,
   output logic          txd
);

   tx_state_t     st;
   logic [DW-1:0] sh;
   logic [BW-1:0] bitn;
   logic          parb, stop_sec;
   logic          last_data, stop_end, par_calc;

   initial begin
      assert (DW >= 2) else $fatal(1, "stq_framer: DW must be at least 2");
   end

   assign last_data = (bitn == (cfg.len8 ? BW'(DW - 1) : BW'(DW - 2)));
   assign stop_end  = !cfg.stop2 || stop_sec;
   assign par_calc  = (cfg.len8 ? ^q_data : ^q_data[DW-2:0]) ^ cfg.par_odd;
   assign pop       = tick && !q_empty &&
                      ((st == ST_IDLE) || ((st == ST_STOP) && stop_end));
   assign idle_done = tick && (st == ST_STOP) && stop_end && q_empty;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         sh       <= '0;
         bitn     <= '0;
         parb     <= 1'b0;
         stop_sec <= 1'b0;
      end else if (tick) begin
         if (pop) begin
            st   <= ST_START;
            sh   <= q_data;
            parb <= par_calc;
         end else begin
            case (st)
               ST_START: begin
                  st   <= ST_DATA;
                  bitn <= '0;
               end
               ST_DATA: begin
                  sh       <= sh >> 1;
                  bitn     <= bitn + 1'b1;
                  stop_sec <= 1'b0;
                  if (last_data) st <= cfg.par_en ? ST_PAR : ST_STOP;
               end
               ST_PAR:  st <= ST_STOP;
               ST_STOP: begin
                  if (!stop_end) stop_sec <= 1'b1;
                  else           st       <= ST_IDLE;
               end
               default: st <= ST_IDLE;
            endcase
         end
      end
   end

   always_comb begin
      case (st)
         ST_START: txd = 1'b0;
         ST_DATA:  txd = sh[0];
         ST_PAR:   txd = parb;
         default:  txd = 1'b1;
      endcase
   end

   // R5: a tick that finds data in an idle engine starts the frame
   a_r5_start_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && (st == ST_IDLE) && !q_empty) |=> !txd);

   // R6: data waiting at the end of the stop period gives a start bit next
   a_r6_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && (st == ST_STOP) && stop_end && !q_empty) |=> !txd);

   // R1: with no tick the line level holds
   a_r1_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(txd));

endmodule

// File: rtl/stq_flags.sv
module stq_flags #(
   parameter int CW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] count,
   input  logic [1:0]    trig_code,
   input  logic          clr_low,
   input  logic          clr_done,
   input  logic          clr_ovf,
   input  logic          wr_accept,
   input  logic          ovf_hit,
   input  logic          idle_done,
   output logic          low_flag,
   output logic          done_flag,
   output logic          ovf_flag
);

   logic [CW-1:0] trig_lvl;
   logic          at_or_below;

   initial begin
      assert (CW >= 4) else $fatal(1, "stq_flags: count too narrow for level 8");
   end

   assign trig_lvl    = (trig_code == 2'd0) ? '0 : (CW'(1) << trig_code);
   assign at_or_below = (count <= trig_lvl);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         low_flag  <= 1'b1;
         done_flag <= 1'b1;
         ovf_flag  <= 1'b0;
      end else begin
         if (at_or_below)  low_flag <= 1'b1;
         else if (clr_low) low_flag <= 1'b0;

         if (wr_accept || clr_done) done_flag <= 1'b0;
         else if (idle_done)        done_flag <= 1'b1;

         if (ovf_hit)      ovf_flag <= 1'b1;
         else if (clr_ovf) ovf_flag <= 1'b0;
      end
   end

   // R7: level at or below the trigger always leaves the flag set
   a_r7_low_sets: assert property (@(posedge clk) disable iff (!rst_n)
      at_or_below |=> low_flag);

   // R9: an accepted write clears the idle flag
   a_r9_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
      wr_accept |=> !done_flag);

   // R10: overflow flag is sticky until cleared
   a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !clr_ovf) |=> ovf_flag);

endmodule

// File: rtl/serial_tx_queue.sv
module serial_tx_queue
   import stq_pkg::*;
#(
   parameter int DW    = 8,
   parameter int DEPTH = 16,
   localparam int CW   = $clog2(DEPTH) + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          baud_tick,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic          cfg_len8,
   input  logic          cfg_par_en,
   input  logic          cfg_par_odd,
   input  logic          cfg_stop2,
   input  logic [1:0]    cfg_trig,
   input  logic          irq_en,
   input  logic          clr_low,
   input  logic          clr_done,
   input  logic          clr_ovf,
   output logic          txd,
   output logic          low_flag,
   output logic          done_flag,
   output logic          ovf_flag,
   output logic          irq
);

   frame_cfg_t    cfg;
   logic [DW-1:0] q_data;
   logic [CW-1:0] q_count;
   logic          q_empty, q_full, q_wr_ok, q_wr_lost;
   logic          pop, idle_done;

   initial begin
      assert (DEPTH > 8) else $fatal(1, "serial_tx_queue: DEPTH must exceed the top trigger level");
   end

   assign cfg = '{len8: cfg_len8, par_en: cfg_par_en,
                  par_odd: cfg_par_odd, stop2: cfg_stop2};

   stq_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (wr_en),
      .wdata   (wr_data),
      .rd      (pop),
      .rdata   (q_data),
      .count   (q_count),
      .empty   (q_empty),
      .full    (q_full),
      .wr_ok   (q_wr_ok),
      .wr_lost (q_wr_lost)
   );

   stq_framer #(.DW(DW)) u_framer (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (baud_tick),
      .cfg       (cfg),
      .q_empty   (q_empty),
      .q_data    (q_data),
      .pop       (pop),
      .idle_done (idle_done),
      .txd       (txd)
   );

   stq_flags #(.CW(CW)) u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .count     (q_count),
      .trig_code (cfg_trig),
      .clr_low   (clr_low),
      .clr_done  (clr_done),
      .clr_ovf   (clr_ovf),
      .wr_accept (q_wr_ok),
      .ovf_hit   (q_wr_lost),
      .idle_done (idle_done),
      .low_flag  (low_flag),
      .done_flag (done_flag),
      .ovf_flag  (ovf_flag)
   );

   assign irq = low_flag && irq_en;

   // R9: the idle flag only rises with the line at mark level
   a_r9_done_at_mark: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_flag) |-> txd);

   // R10: a lost write always leaves the overflow flag set
   a_r10_lost_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && q_full) |=> ovf_flag);

endmodule

// File: tb/serial_tx_queue_test.sv
module serial_tx_queue_test;

   localparam int BAUD = 8;

   typedef struct {
      logic [11:0] bits;
      int          n;
      bit          b2b;
   } exp_frame_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_on = 1'b0;
   logic       baud_tick;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       cfg_len8 = 1'b1, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_stop2 = 1'b0;
   logic [1:0] cfg_trig = 2'd0;
   logic       irq_en = 1'b0, clr_low = 1'b0, clr_done = 1'b0, clr_ovf = 1'b0;
   logic       txd, low_flag, done_flag, ovf_flag, irq;

   int total = 0, bad = 0, cyc = 0;
   int frames_sent = 0, frames_done = 0;
   int tdiv = 0;
   bit finished = 0;
   exp_frame_t q[$];

   always #4 clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      tdiv <= (tdiv == BAUD - 1) ? 0 : tdiv + 1;
   end
   assign baud_tick = tick_on && (tdiv == BAUD - 1);

   serial_tx_queue uut (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
      .wr_en(wr_en), .wr_data(wr_data),
      .cfg_len8(cfg_len8), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
      .cfg_stop2(cfg_stop2), .cfg_trig(cfg_trig), .irq_en(irq_en),
      .clr_low(clr_low), .clr_done(clr_done), .clr_ovf(clr_ovf),
      .txd(txd), .low_flag(low_flag), .done_flag(done_flag),
      .ovf_flag(ovf_flag), .irq(irq)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic exp_frame_t build(input logic [7:0] d, input bit b2b);
      exp_frame_t f;
      int len;
      f.bits = '1;
      f.n = 0;
      f.b2b = b2b;
      len = cfg_len8 ? 8 : 7;
      f.bits[f.n] = 1'b0; f.n++;
      for (int i = 0; i < len; i++) begin
         f.bits[f.n] = d[i]; f.n++;
      end
      if (cfg_par_en) begin
         f.bits[f.n] = (cfg_len8 ? ^d : ^d[6:0]) ^ cfg_par_odd; f.n++;
      end
      f.bits[f.n] = 1'b1; f.n++;
      if (cfg_stop2) begin
         f.bits[f.n] = 1'b1; f.n++;
      end
      return f;
   endfunction

   // driver: one write; keep=0 when the bench knows the queue is full
   task automatic send(input logic [7:0] d, input bit keep, input bit b2b);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = d;
      if (keep) begin
         q.push_back(build(d, b2b));
         frames_sent++;
      end
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse(ref logic sig);
      @(negedge clk);
      sig = 1'b1;
      @(negedge clk);
      sig = 1'b0;
   endtask

   task automatic drain();
      while (!(frames_done == frames_sent && done_flag === 1'b1)) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   // monitor: recover frames from txd and compare against the queue
   initial begin
      int prev_start, prev_n, start;
      exp_frame_t e;
      logic [11:0] got, mask;
      prev_start = 0;
      prev_n = 0;
      forever begin
         @(negedge clk);
         if (rst_n && txd === 1'b0) begin
            start = cyc;
            if (q.size() == 0) begin
               chk(0, "R2", "unexpected start bit", 0, 1);
               while (txd !== 1'b1) @(negedge clk);
            end else begin
               e = q.pop_front();
               got = '1;
               repeat (BAUD / 2) @(negedge clk);
               got[0] = txd;
               for (int k = 1; k < e.n; k++) begin
                  repeat (BAUD) @(negedge clk);
                  got[k] = txd;
               end
               mask = 12'((1 << e.n) - 1);
               chk(((got ^ e.bits) & mask) == 0, "R2 R3 R4", "frame bits",
                   int'(got & mask), int'(e.bits & mask));
               if (e.b2b)
                  chk(start - prev_start == prev_n * BAUD, "R6",
                      "start spacing", start - prev_start, prev_n * BAUD);
               prev_start = start;
               prev_n = e.n;
               frames_done++;
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int w;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(txd === 1'b1, "R1", "txd after reset", txd, 1);
      chk(low_flag === 1'b1, "R1", "low_flag after reset", low_flag, 1);
      chk(done_flag === 1'b1, "R1", "done_flag after reset", done_flag, 1);
      chk(ovf_flag === 1'b0, "R1", "ovf_flag after reset", ovf_flag, 0);
      chk(irq === 1'b0, "R8", "irq with enable off", irq, 0);

      // R8 irq follows enable; R7 clear loses while level is at trigger
      irq_en = 1'b1;
      @(negedge clk);
      chk(irq === 1'b1, "R8", "irq with enable on", irq, 1);
      pulse(clr_low);
      @(negedge clk);
      chk(low_flag === 1'b1, "R7", "clear while at trigger", low_flag, 1);

      // burst with ticks stopped: 8-bit, even parity, one stop, trigger 2
      cfg_len8 = 1; cfg_par_en = 1; cfg_par_odd = 0; cfg_stop2 = 0; cfg_trig = 2'd1;
      send(8'hA5, 1, 0);
      @(negedge clk);
      chk(done_flag === 1'b0, "R9", "write clears done_flag", done_flag, 0);
      send(8'h3C, 1, 1);
      send(8'h01, 1, 1);
      send(8'hFE, 1, 1);
      @(negedge clk);
      pulse(clr_low);
      @(negedge clk);
      chk(low_flag === 1'b0, "R7", "clear above trigger", low_flag, 0);
      chk(irq === 1'b0, "R8", "irq follows cleared flag", irq, 0);
      tick_on = 1'b1;
      drain();
      chk(low_flag === 1'b1, "R7", "flag re-set after drain", low_flag, 1);
      chk(done_flag === 1'b1, "R9", "done_flag after last stop", done_flag, 1);
      chk(txd === 1'b1, "R1", "idle line after burst", txd, 1);

      // R9 explicit clear while idle stays clear
      pulse(clr_done);
      repeat (20) @(negedge clk);
      chk(done_flag === 1'b0, "R9", "clr_done while idle", done_flag, 0);

      // R5 single write: 7-bit, odd parity, two stop
      cfg_len8 = 0; cfg_par_en = 1; cfg_par_odd = 1; cfg_stop2 = 1;
      send(8'hD3, 1, 0);
      w = cyc;
      while (txd !== 1'b0) @(negedge clk);
      chk(cyc - w <= BAUD + 1, "R5", "write to start-bit delay", cyc - w, BAUD + 1);
      drain();

      // 8-bit, no parity, one stop, burst with ticks running
      cfg_len8 = 1; cfg_par_en = 0; cfg_par_odd = 0; cfg_stop2 = 0;
      send(8'h80, 1, 0);
      send(8'h7F, 1, 1);
      send(8'h55, 1, 1);
      drain();

      // 7-bit, no parity, two stop; bit 7 set must be ignored
      cfg_len8 = 0; cfg_par_en = 0; cfg_stop2 = 1;
      send(8'hC1, 1, 0);
      send(8'h80, 1, 1);
      drain();

      // R10 overflow: 17 writes with ticks stopped, 16 kept
      tick_on = 1'b0;
      cfg_len8 = 1; cfg_par_en = 1; cfg_par_odd = 1; cfg_stop2 = 0;
      for (int i = 0; i < 17; i++) send(8'(i * 37 + 11), i < 16, i != 0);
      @(negedge clk);
      chk(ovf_flag === 1'b1, "R10", "overflow sticky set", ovf_flag, 1);
      tick_on = 1'b1;
      drain();
      chk(ovf_flag === 1'b1, "R10", "overflow held until clear", ovf_flag, 1);
      pulse(clr_ovf);
      @(negedge clk);
      chk(ovf_flag === 1'b0, "R10", "overflow cleared", ovf_flag, 0);

      // R7 boundary at trigger 8
      tick_on = 1'b0;
      cfg_trig = 2'd3;
      for (int i = 0; i < 8; i++) send(8'(8'h20 + i), 1, i != 0);
      @(negedge clk);
      pulse(clr_low);
      @(negedge clk);
      chk(low_flag === 1'b1, "R7", "clear at level 8 trigger 8", low_flag, 1);
      send(8'h99, 1, 1);
      @(negedge clk);
      pulse(clr_low);
      @(negedge clk);
      chk(low_flag === 1'b0, "R7", "clear at level 9 trigger 8", low_flag, 0);
      tick_on = 1'b1;
      drain();
      chk(q.size() == 0, "R2", "all expected frames seen", q.size(), 0);

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule